// File: doc/BRIEF.md
# Interrupt Request Priority Arbiter

This block tracks 256 interrupt vectors for a local interrupt controller. A source hands it a vector with a level or edge flag, and the vector becomes pending. When the processor asks for an interrupt, the block returns the best pending vector in the same cycle. At the next clock edge that vector moves from pending to in service. An end-of-interrupt strobe retires the highest vector that is in service. If that vector was level triggered, the block sends a remote end-of-interrupt strobe that carries the vector, so the upstream source can re-arm.

The block holds three 256-bit arrays: pending requests, in service, and trigger mode. It also holds an 8-bit task-priority value. A grant needs two things. The top pending vector must be above every vector in service. Its priority class, the upper nibble, must also be strictly above the class in the task-priority value. A 32-bit read port exposes each array word by word, and also the task-priority value.

The block has no state machine. Its sequencing is the fixed order in which a single cycle applies acknowledge, end of interrupt, delivery and the task-priority write (R10).

Top module: `irq_prio_arb`

## Requirements
- R1: A valid delivery of vector v sets pending bit v at the next edge. It sets trigger bit v when `dlv_level`=1 and clears it when `dlv_level`=0. Bit v lies in array word v>>5, bit position v&31.
- R2: A delivery of a vector whose pending bit is already set is dropped. The pending, in-service and trigger arrays all stay unchanged.
- R3: A delivery of a vector below 0x10, or of vector 0xFF, raises `dlv_bad` in the same cycle and changes no state.
- R4: When `ack_req`=1, the block grants if all three of these hold:
  - some pending bit is set;
  - the highest pending vector P is above the highest in-service vector (or nothing is in service);
  - P[7:4] > TPR[7:4].
  On a grant, `ack_grant`=1 and `ack_vec`=P in that cycle. At the next edge, pending bit P clears and in-service bit P sets.
- R5: When any grant condition fails, `ack_grant`=0 and `ack_vec`=0, and the acknowledge changes no state.
- R6: On `eoi_wr` with some bit in service, the highest in-service bit S clears at the next edge. If trigger bit S was set, then `reoi_valid`=1 and `reoi_vec`=S for the one cycle after the edge. Otherwise `reoi_valid`=0 and `reoi_vec`=0.
- R7: `eoi_wr` while nothing is in service has no effect and produces no remote strobe.
- R8: A `tpr_wr` stores only bits 7:0 of `tpr_wdata`. Address 0x080 reads that value zero-extended to 32 bits.
- R9: The read port is combinational:
  - in-service word k is at 0x100+0x10·k;
  - trigger word k is at 0x180+0x10·k;
  - pending word k is at 0x200+0x10·k (k = 0..7);
  - any other address reads 0.
- R10: In one cycle, operations take effect in this order:
  - the acknowledge, which uses the state before the cycle;
  - end of interrupt, which uses the in-service and trigger state before the cycle;
  - delivery, whose drop test sees the pending bits after the acknowledge's clear;
  - the TPR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all arrays and TPR |
| dlv_valid | input | 1 | Delivery strobe |
| dlv_vec | input | 8 | Delivered vector |
| dlv_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| dlv_bad | output | 1 | Delivered vector is invalid (combinational) |
| ack_req | input | 1 | Processor acknowledge request |
| ack_grant | output | 1 | Acknowledge granted this cycle |
| ack_vec | output | 8 | Granted vector, 0 when no grant |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| reoi_valid | output | 1 | Remote end-of-interrupt strobe (registered) |
| reoi_vec | output | 8 | Vector carried by the remote strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Register read data |

## Verification
The bench builds the block with its package defaults: 8-bit vectors, 256 vectors and eight 32-bit words per array. Full-size arrays bring several cases within reach:
- the invalid low range and the 0xFF vector;
- every array word and bit position through the read map;
- grants that the class rule blocks although the vector itself is above the TPR value.

A long mixed-traffic phase makes acknowledge, end of interrupt, delivery and TPR writes coincide in one cycle. This exercises the ordering rule against the reference model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int WORD_W    = 32;
    localparam int NWORDS    = NUM_VEC / WORD_W;
    localparam int WSEL_W    = $clog2(NWORDS);
    localparam int WORD_SH   = $clog2(WORD_W);
    localparam int ADDR_W    = 12;
    localparam int STRIDE_SH = 4;
    localparam int BLK_LSB   = STRIDE_SH + WSEL_W;
    localparam int CLASS_LSB = 4;
    localparam int MIN_VALID = 16;

    localparam logic [ADDR_W-1:0] TPR_ADDR = 12'h080;
    localparam logic [ADDR_W-1:0] ISR_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] TMR_BASE = 12'h180;
    localparam logic [ADDR_W-1:0] IRR_BASE = 12'h200;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_take,
    input  logic [VEC_W-1:0]   ack_idx,
    input  logic               eoi_take,
    input  logic [VEC_W-1:0]   eoi_idx,
    input  logic               dlv_ok,
    input  logic [VEC_W-1:0]   dlv_idx,
    input  logic               dlv_level,
    output logic [NUM_VEC-1:0] irr_q,
    output logic [NUM_VEC-1:0] isr_q,
    output logic [NUM_VEC-1:0] tmr_q
);
    logic [NUM_VEC-1:0] irr_mid;
    logic               dlv_new;

    assign dlv_new = dlv_ok && !irr_mid[dlv_idx];

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
        logic hit_ack, hit_eoi, hit_dlv;
        assign hit_ack    = ack_take && (ack_idx == VEC_W'(i));
        assign hit_eoi    = eoi_take && (eoi_idx == VEC_W'(i));
        assign hit_dlv    = dlv_new  && (dlv_idx == VEC_W'(i));
        assign irr_mid[i] = irr_q[i] && !hit_ack;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irr_q[i] <= 1'b0;
                isr_q[i] <= 1'b0;
                tmr_q[i] <= 1'b0;
            end else begin
                irr_q[i] <= irr_mid[i] || hit_dlv;
                isr_q[i] <= (isr_q[i] && !hit_eoi) || hit_ack;
                if (hit_dlv) begin
                    tmr_q[i] <= dlv_level;
                end
            end
        end
    end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
    import irq_arb_pkg::*;
(
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [NUM_VEC-1:0] irr_q,
    input  logic [NUM_VEC-1:0] isr_q,
    input  logic [NUM_VEC-1:0] tmr_q,
    input  logic [VEC_W-1:0]   tpr_q,
    output logic [WORD_W-1:0]  rd_data
);
    logic [WSEL_W-1:0]         widx;
    logic [WSEL_W+WORD_SH-1:0] base;
    logic [ADDR_W-1:BLK_LSB]   blk;

    assign widx = rd_addr[BLK_LSB-1:STRIDE_SH];
    assign base = {widx, {WORD_SH{1'b0}}};
    assign blk  = rd_addr[ADDR_W-1:BLK_LSB];

    always_comb begin
        rd_data = '0;
        if (rd_addr[STRIDE_SH-1:0] == '0) begin
            if (rd_addr == TPR_ADDR) begin
                rd_data = {{(WORD_W-VEC_W){1'b0}}, tpr_q};
            end else if (blk == ISR_BASE[ADDR_W-1:BLK_LSB]) begin
                rd_data = isr_q[base +: WORD_W];
            end else if (blk == TMR_BASE[ADDR_W-1:BLK_LSB]) begin
                rd_data = tmr_q[base +: WORD_W];
            end else if (blk == IRR_BASE[ADDR_W-1:BLK_LSB]) begin
                rd_data = irr_q[base +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlv_valid,
    input  logic [VEC_W-1:0]  dlv_vec,
    input  logic              dlv_level,
    output logic              dlv_bad,
    input  logic              ack_req,
    output logic              ack_grant,
    output logic [VEC_W-1:0]  ack_vec,
    input  logic              eoi_wr,
    output logic              reoi_valid,
    output logic [VEC_W-1:0]  reoi_vec,
    input  logic              tpr_wr,
    input  logic [WORD_W-1:0] tpr_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [VEC_W-1:0]   tpr_q;
    logic               irr_any, isr_any;
    logic [VEC_W-1:0]   irr_hi, isr_hi;
    logic               grant_ok, dlv_inv, dlv_ok, eoi_take;
    logic               unused_tpr_hi;

    assign unused_tpr_hi = ^tpr_wdata[WORD_W-1:VEC_W];

    irq_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) u_enc_irr (
        .bits(irr_q), .any(irr_any), .idx(irr_hi)
    );
    irq_prio_enc #(.W(NUM_VEC), .IW(VEC_W)) u_enc_isr (
        .bits(isr_q), .any(isr_any), .idx(isr_hi)
    );

    always_comb begin
        grant_ok = irr_any
                && (!isr_any || (irr_hi > isr_hi))
                && (irr_hi[VEC_W-1:CLASS_LSB] > tpr_q[VEC_W-1:CLASS_LSB]);
        dlv_inv  = (dlv_vec < VEC_W'(MIN_VALID)) || (&dlv_vec);
        dlv_ok   = dlv_valid && !dlv_inv;
        eoi_take = eoi_wr && isr_any;
    end

    assign dlv_bad   = dlv_valid && dlv_inv;
    assign ack_grant = ack_req && grant_ok;
    assign ack_vec   = ack_grant ? irr_hi : '0;

    irq_vec_state u_state (
        .clk(clk), .rst_n(rst_n),
        .ack_take(ack_grant), .ack_idx(irr_hi),
        .eoi_take(eoi_take), .eoi_idx(isr_hi),
        .dlv_ok(dlv_ok), .dlv_idx(dlv_vec), .dlv_level(dlv_level),
        .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q      <= '0;
            reoi_valid <= 1'b0;
            reoi_vec   <= '0;
        end else begin
            if (tpr_wr) begin
                tpr_q <= tpr_wdata[VEC_W-1:0];
            end
            reoi_valid <= eoi_take && tmr_q[isr_hi];
            reoi_vec   <= (eoi_take && tmr_q[isr_hi]) ? isr_hi : '0;
        end
    end

    irq_reg_read u_read (
        .rd_addr(rd_addr), .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q),
        .tpr_q(tpr_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
    import irq_arb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               dlv_bad,
    input logic               ack_req,
    input logic               ack_grant,
    input logic [VEC_W-1:0]   ack_vec,
    input logic               eoi_wr,
    input logic               reoi_valid,
    input logic [VEC_W-1:0]   reoi_vec,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [NUM_VEC-1:0] tmr_q,
    input logic [VEC_W-1:0]   tpr_q
);
    logic               g_d;
    logic [VEC_W-1:0]   gv_d;
    logic [NUM_VEC-1:0] tmr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_d   <= 1'b0;
            gv_d  <= '0;
            tmr_d <= '0;
        end else begin
            g_d   <= ack_grant;
            gv_d  <= ack_vec;
            tmr_d <= tmr_q;
        end
    end

    // R3: an invalid delivery leaves the pending and trigger arrays alone
    p_bad_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_bad && !ack_req) |=> ($stable(irr_q) && $stable(tmr_q)));

    // R4: a granted class is strictly above the task-priority class
    p_grant_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_grant |-> (ack_vec[VEC_W-1:CLASS_LSB] > tpr_q[VEC_W-1:CLASS_LSB]));

    // R4: a granted vector is pending and above everything in service
    p_grant_above_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_grant |-> (irr_q[ack_vec] && ((isr_q >> ack_vec) == '0)));

    // R4: a grant moves the vector into service
    p_grant_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        g_d |-> (isr_q[gv_d] && !irr_q[gv_d]) || irr_q[gv_d]);

    // R6: a remote strobe follows an end of interrupt on a level vector
    p_reoi_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reoi_valid |-> ($past(eoi_wr) && tmr_d[reoi_vec] && !isr_q[reoi_vec]));

    // R7: end of interrupt with nothing in service emits no strobe
    p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && (isr_q == '0)) |=> !reoi_valid);
endmodule

bind irq_prio_arb irq_prio_arb_chk chk_i (
    .clk(clk), .rst_n(rst_n), .dlv_bad(dlv_bad), .ack_req(ack_req),
    .ack_grant(ack_grant), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
    .reoi_valid(reoi_valid), .reoi_vec(reoi_vec),
    .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q), .tpr_q(tpr_q)
);

// File: tb/irq_prio_arb_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlv_valid = 1'b0, dlv_level = 1'b0, ack_req = 1'b0;
    logic        eoi_wr = 1'b0, tpr_wr = 1'b0;
    logic [7:0]  dlv_vec = '0;
    logic [31:0] tpr_wdata = '0;
    logic [11:0] rd_addr = '0;
    logic        dlv_bad, ack_grant, reoi_valid;
    logic [7:0]  ack_vec, reoi_vec;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    irq_prio_arb dut_i (
        .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec),
        .dlv_level(dlv_level), .dlv_bad(dlv_bad), .ack_req(ack_req),
        .ack_grant(ack_grant), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
        .reoi_valid(reoi_valid), .reoi_vec(reoi_vec), .tpr_wr(tpr_wr),
        .tpr_wdata(tpr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int          n_chk = 0, n_err = 0;
    bit          finished = 1'b0;
    string       tag = "R9";
    string       reoi_tag = "R6";
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]  m_tpr = '0;
    logic        e_rv = 1'b0;
    logic [7:0]  e_rvec = '0;

    function automatic int top_bit(input logic [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k;
        if (a[3:0] != 0) return 32'h0;
        if (a == 12'h080) return {24'h0, m_tpr};
        k = (a >> 4) & 7;
        if (a >= 12'h100 && a < 12'h180) return m_isr[k*32 +: 32];
        if (a >= 12'h180 && a < 12'h200) return m_tmr[k*32 +: 32];
        if (a >= 12'h200 && a < 12'h280) return m_irr[k*32 +: 32];
        return 32'h0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic dv, input logic [7:0] dvec, input logic dl,
                        input logic ak, input logic eo, input logic tw,
                        input logic [31:0] twd, input logic [11:0] ra);
        int  ih, sh;
        logic g, bad;
        @(negedge clk);
        dlv_valid = dv; dlv_vec = dvec; dlv_level = dl; ack_req = ak;
        eoi_wr = eo; tpr_wr = tw; tpr_wdata = twd; rd_addr = ra;
        #1;
        ih  = top_bit(m_irr);
        sh  = top_bit(m_isr);
        g   = ak && ih >= 0 && ih > sh && (ih / 16) > (m_tpr / 16);
        bad = dv && (dvec < 8'h10 || dvec == 8'hFF);
        chk(g ? "R4" : "R5", "ack_grant", {31'h0, ack_grant}, {31'h0, g});
        chk(g ? "R4" : "R5", "ack_vec", {24'h0, ack_vec}, g ? ih : 0);
        chk("R3", "dlv_bad", {31'h0, dlv_bad}, {31'h0, bad});
        chk(tag, "rd_data", rd_data, model_read(ra));
        chk(reoi_tag, "reoi", {23'h0, reoi_valid, reoi_vec}, {23'h0, e_rv, e_rvec});
        @(posedge clk);
        if (g) begin m_irr[ih] = 1'b0; m_isr[ih] = 1'b1; end
        reoi_tag = (eo && sh < 0) ? "R7" : "R6";
        if (eo && sh >= 0) begin
            m_isr[sh] = 1'b0;
            e_rv   = m_tmr[sh];
            e_rvec = m_tmr[sh] ? 8'(sh) : 8'h0;
        end else begin
            e_rv = 1'b0; e_rvec = 8'h0;
        end
        if (dv && !bad && !m_irr[dvec]) begin
            m_irr[dvec] = 1'b1;
            m_tmr[dvec] = dl;
        end
        if (tw) m_tpr = twd[7:0];
    endtask

    task automatic idle(input logic [11:0] ra);
        step(0, 8'h0, 0, 0, 0, 0, 32'h0, ra);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state reads zero everywhere, R5 no grant when empty
        tag = "R9";
        idle(12'h100); idle(12'h200); idle(12'h080);
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h1F0);
        // R1: level delivery 0x45 -> word 2 bit 5
        tag = "R1";
        step(1, 8'h45, 1, 0, 0, 0, 32'h0, 12'h000);
        idle(12'h220); idle(12'h1A0);
        step(1, 8'h9F, 0, 0, 0, 0, 32'h0, 12'h000);
        idle(12'h240);
        // R2: redelivery of 0x45 edge is dropped, trigger bit stays set
        tag = "R2";
        step(1, 8'h45, 0, 0, 0, 0, 32'h0, 12'h000);
        idle(12'h1A0); idle(12'h220);
        // R3: invalid vectors flagged and not stored
        tag = "R3";
        step(1, 8'h05, 1, 0, 0, 0, 32'h0, 12'h200);
        step(1, 8'hFF, 1, 0, 0, 0, 32'h0, 12'h200);
        idle(12'h270); idle(12'h200);
        // R8: TPR keeps low byte; class 0x9 blocks 0x9F, then lower it
        tag = "R8";
        step(0, 8'h0, 0, 0, 0, 1, 32'hFFFF_FF95, 12'h000);
        idle(12'h080);
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h080);
        step(0, 8'h0, 0, 0, 0, 1, 32'h0000_0030, 12'h000);
        idle(12'h080);
        // R4: grants in priority order, then blocked by in-service
        tag = "R4";
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h000);
        idle(12'h140);
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h000);
        idle(12'h120);
        step(1, 8'h50, 0, 1, 0, 0, 32'h0, 12'h220);
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h220);
        // R6: end of interrupt: 0x9F edge (no strobe), 0x50 not in service
        tag = "R6";
        step(0, 8'h0, 0, 0, 1, 0, 32'h0, 12'h140);
        idle(12'h140);
        step(0, 8'h0, 0, 1, 0, 0, 32'h0, 12'h000);
        step(0, 8'h0, 0, 0, 1, 0, 32'h0, 12'h000);
        step(0, 8'h0, 0, 0, 1, 0, 32'h0, 12'h120);
        idle(12'h120);
        // R7: end of interrupt with nothing in service
        tag = "R7";
        step(0, 8'h0, 0, 0, 1, 0, 32'h0, 12'h100);
        idle(12'h100); idle(12'h120);
        // R10: simultaneous acknowledge and redelivery of same vector
        tag = "R10";
        step(1, 8'h60, 1, 0, 0, 0, 32'h0, 12'h000);
        step(1, 8'h60, 0, 1, 0, 0, 32'h0, 12'h000);
        idle(12'h230); idle(12'h1B0); idle(12'h130);
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  v;
            logic [11:0] a;
            int          r;
            v = 8'($urandom_range(0, 255));
            r = $urandom_range(0, 9);
            if (r < 4)      a = 12'h100 + 12'($urandom_range(0, 23) * 16);
            else if (r < 5) a = 12'h080;
            else if (r < 6) a = 12'($urandom_range(0, 4095));
            else            a = 12'h200 + 12'($urandom_range(0, 7) * 16);
            step($urandom_range(0, 9) < 6, v, 1'($urandom_range(0, 1)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 9) < 3,
                 $urandom_range(0, 49) == 0, 32'($urandom_range(0, 63)), a);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule